// File: doc/BRIEF.md
# Edge-Selectable Input Capture Channel

This block is one channel of a timer operating in capture mode. It watches an asynchronous external pin, brings it into the clock domain through a chain of synchronizer flops, and compares each synchronized sample against the one before it to find rising and falling transitions. A two-bit edge selector decides which transitions count. When a counted transition arrives, the current value of a shared free-running counter is stored in the channel's timestamp register and the channel's event flag is raised.

Software reads the stored timestamp and clears the flag by writing a one to the flag bit. An interrupt request is presented while the flag is set and the channel's interrupt enable is on. A channel that is configured for compare duty never captures. Pulse-width and period arithmetic is left to software, which subtracts two timestamps modulo the counter width.

Top module: `edge_capture_chan`

## Requirements
- R1: After reset the stored timestamp is 0, the event flag is 0 and the interrupt request is 0.
- R2: With edge selector 2'b01, a low-to-high pin transition captures and a high-to-low transition does not.
- R3: With edge selector 2'b10, a high-to-low pin transition captures and a low-to-high transition does not.
- R4: With edge selector 2'b11, both pin transitions capture.
- R5: With edge selector 2'b00, no pin transition captures, and the timestamp and flag are left unchanged.
- R6: The stored timestamp equals the counter input as presented at the third rising clock edge that samples the new pin level, with the first edge that samples it counted as the first. With two synchronizer stages, this is two edges of latency plus the edge that stores the value.
- R7: The event flag is set on the same clock edge that stores the timestamp.
- R8: The interrupt request is 1 exactly while the flag is 1 and the interrupt enable is 1.
- R9: A flag write strobe with data bit 1 clears the flag on the next edge. A strobe with data bit 0 leaves the flag set.
- R10: When a capture and a clearing write fall on the same edge, the flag ends set.
- R11: A qualifying transition overwrites the timestamp even while the flag is still set.
- R12: While the channel select input is 1 (compare duty), no transition captures.
- R13: The timestamp holds its value on every edge without a qualifying transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw external pin, asynchronous |
| count_in | input | CNT_W | Free-running counter value |
| edge_sel | input | 2 | 00 off, 01 rising, 10 falling, 11 both |
| cmp_mode | input | 1 | 1 = channel used for compare, capture disabled |
| irq_en | input | 1 | Channel interrupt enable |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wr_bit | input | 1 | Data for this channel's flag bit, 1 clears |
| cap_value | output | CNT_W | Stored timestamp |
| cap_flag | output | 1 | Event flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
Every edge-selector setting is driven with both a rising and a falling pin transition. This shows that each code picks exactly its own transitions and that the off code and compare duty block both. Back-to-back captures with no clear in between show that the timestamp is overwritten even though the flag stays set. A clearing write placed on the capture edge shows which of the two wins. Each expected timestamp is predicted from the pin change cycle plus the synchronizer latency, so a wrong stage count or a missing edge register shows up as a value off by one.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cap_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= IDLE_LVL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= IDLE_LVL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det
   import cap_pkg::*;
#(
   parameter logic IDLE_LVL = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl,
   input  edge_sel_e sel,
   input  logic      allow,
   output logic      hit
);
   logic prev_lvl;
   logic is_rise;
   logic is_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_lvl <= IDLE_LVL;
      else        prev_lvl <= lvl;
   end

   assign is_rise = lvl & ~prev_lvl;
   assign is_fall = ~lvl & prev_lvl;

   always_comb begin
      unique case (sel)
         EDGE_RISE: hit = allow & is_rise;
         EDGE_FALL: hit = allow & is_fall;
         EDGE_ANY:  hit = allow & (is_rise | is_fall);
         default:   hit = 1'b0;
      endcase
   end

   // R5: the off code never qualifies a transition
   assert_off_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == EDGE_OFF) |-> !hit);
   // R2: in rising mode a hit only follows a low sample
   assert_rise_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel == EDGE_RISE) |-> (lvl && !prev_lvl));
   // R3: in falling mode a hit only follows a high sample
   assert_fall_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel == EDGE_FALL) |-> (!lvl && prev_lvl));
endmodule

// File: rtl/cap_latch.sv
module cap_latch #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [CNT_W-1:0] count_in,
   input  logic             flag_wr,
   input  logic             flag_wr_bit,
   input  logic             irq_en,
   output logic [CNT_W-1:0] value,
   output logic             flag,
   output logic             irq
);
   logic clr_req;

   assign clr_req = flag_wr & flag_wr_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   value <= '0;
      else if (hit) value <= count_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (hit)      flag <= 1'b1;
      else if (clr_req)  flag <= 1'b0;
   end

   assign irq = flag & irq_en;

   // R7: the flag is up right after each capture
   assert_flag_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);
   // R9: a clearing write without a capture drops the flag
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !hit) |=> !flag);
   // R13: the timestamp holds without a capture
   assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(value));
   // R8: no request without a pending flag
   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);
endmodule

// File: rtl/edge_capture_chan.sv
module edge_capture_chan
   import cap_pkg::*;
#(
   parameter int   CNT_W       = 16,
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_IDLE    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic [CNT_W-1:0] count_in,
   input  logic [1:0]       edge_sel,
   input  logic             cmp_mode,
   input  logic             irq_en,
   input  logic             flag_wr,
   input  logic             flag_wr_bit,
   output logic [CNT_W-1:0] cap_value,
   output logic             cap_flag,
   output logic             cap_irq
);
   localparam int TOTAL_LAT = SYNC_STAGES + 1;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("edge_capture_chan: CNT_W must be at least 2");
      end
      if (TOTAL_LAT > 8) begin : g_bad_lat
         $error("edge_capture_chan: synchronizer chain too deep");
      end
   endgenerate

   logic pin_sync;
   logic hit;

   cap_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(PIN_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   cap_edge_det #(.IDLE_LVL(PIN_IDLE)) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (pin_sync),
      .sel   (edge_sel_e'(edge_sel)),
      .allow (~cmp_mode),
      .hit   (hit)
   );

   cap_latch #(.CNT_W(CNT_W)) u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit         (hit),
      .count_in    (count_in),
      .flag_wr     (flag_wr),
      .flag_wr_bit (flag_wr_bit),
      .irq_en      (irq_en),
      .value       (cap_value),
      .flag        (cap_flag),
      .irq         (cap_irq)
   );

   // R12: compare duty blocks every capture
   assert_cmp_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_mode |-> !hit);
   // R10: a capture beats a simultaneous clear
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && flag_wr && flag_wr_bit) |=> cap_flag);
   // R11: a capture loads the counter even while the flag is pending
   assert_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cap_flag) |=> (cap_value == $past(count_in)));
endmodule

// File: tb/test_edge_capture_chan.sv
module test_edge_capture_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_in = 1'b0;
   logic [15:0] cnt;
   logic [1:0]  edge_sel = 2'b00;
   logic        cmp_mode = 1'b0;
   logic        irq_en = 1'b0;
   logic        flag_wr = 1'b0;
   logic        flag_wr_bit = 1'b0;
   logic [15:0] cap_value;
   logic        cap_flag;
   logic        cap_irq;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [15:0] exp_q[$];
   logic [15:0] last_val = 16'h0;

   always #5 clk = ~clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= 16'h0;
      else        cnt <= cnt + 16'h1;
   end

   edge_capture_chan i_edge_capture_chan (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .count_in(cnt),
      .edge_sel(edge_sel), .cmp_mode(cmp_mode), .irq_en(irq_en),
      .flag_wr(flag_wr), .flag_wr_bit(flag_wr_bit),
      .cap_value(cap_value), .cap_flag(cap_flag), .cap_irq(cap_irq)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: every new timestamp must match the next predicted one (R6)
   always @(negedge clk) begin
      if (rst_n && cap_value != last_val) begin
         if (exp_q.size() == 0)
            check(1'b0, "R6 unexpected capture", cap_value, last_val);
         else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check(cap_value == e, "R6 timestamp", cap_value, e);
         end
         last_val = cap_value;
      end
   end

   // Driver: change the pin, predict the stored counter if it qualifies
   task automatic drive_pin(input logic lvl, input bit qual);
      @(negedge clk);
      pin_in = lvl;
      if (qual) exp_q.push_back(cnt + 16'd2);
      repeat (4) @(negedge clk);
   endtask

   task automatic write_flag(input logic b);
      @(negedge clk);
      flag_wr = 1'b1;
      flag_wr_bit = b;
      @(negedge clk);
      flag_wr = 1'b0;
      flag_wr_bit = 1'b0;
   endtask

   initial begin
      logic [15:0] held;
      repeat (3) @(negedge clk);
      check(cap_value == 16'h0, "R1 value", cap_value, 16'h0);
      check(cap_flag == 1'b0, "R1 flag", {15'h0, cap_flag}, 16'h0);
      check(cap_irq == 1'b0, "R1 irq", {15'h0, cap_irq}, 16'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R2: rising mode
      edge_sel = 2'b01;
      drive_pin(1'b1, 1'b1);
      check(cap_flag == 1'b1, "R7 flag after capture", {15'h0, cap_flag}, 16'h1);
      check(cap_irq == 1'b0, "R8 irq masked", {15'h0, cap_irq}, 16'h0);
      irq_en = 1'b1;
      @(negedge clk);
      check(cap_irq == 1'b1, "R8 irq enabled", {15'h0, cap_irq}, 16'h1);
      held = cap_value;
      drive_pin(1'b0, 1'b0);
      check(cap_value == held, "R2 falling ignored", cap_value, held);

      // R9: write of 0 keeps, write of 1 clears
      write_flag(1'b0);
      check(cap_flag == 1'b1, "R9 zero write keeps flag", {15'h0, cap_flag}, 16'h1);
      write_flag(1'b1);
      check(cap_flag == 1'b0, "R9 one write clears flag", {15'h0, cap_flag}, 16'h0);
      check(cap_irq == 1'b0, "R8 irq drops with flag", {15'h0, cap_irq}, 16'h0);

      // R3: falling mode
      edge_sel = 2'b10;
      held = cap_value;
      drive_pin(1'b1, 1'b0);
      check(cap_value == held && !cap_flag, "R3 rising ignored", cap_value, held);
      drive_pin(1'b0, 1'b1);
      check(cap_flag == 1'b1, "R3 falling captured", {15'h0, cap_flag}, 16'h1);

      // R4 and R11: both edges, no clear in between
      edge_sel = 2'b11;
      drive_pin(1'b1, 1'b1);
      drive_pin(1'b0, 1'b1);
      check(exp_q.size() == 0, "R11 overwrite while flagged",
            16'(exp_q.size()), 16'h0);
      check(cap_flag == 1'b1, "R4 flag still set", {15'h0, cap_flag}, 16'h1);
      write_flag(1'b1);

      // R5: off code
      edge_sel = 2'b00;
      held = cap_value;
      drive_pin(1'b1, 1'b0);
      drive_pin(1'b0, 1'b0);
      check(cap_value == held && !cap_flag, "R5 off code", cap_value, held);

      // R12: compare duty
      edge_sel = 2'b11;
      cmp_mode = 1'b1;
      drive_pin(1'b1, 1'b0);
      drive_pin(1'b0, 1'b0);
      check(cap_value == held && !cap_flag, "R12 compare duty", cap_value, held);
      cmp_mode = 1'b0;

      // R10: clear lands on the capture edge
      @(negedge clk);
      pin_in = 1'b1;
      exp_q.push_back(cnt + 16'd2);
      @(negedge clk);
      @(negedge clk);
      flag_wr = 1'b1;
      flag_wr_bit = 1'b1;
      @(negedge clk);
      flag_wr = 1'b0;
      flag_wr_bit = 1'b0;
      check(cap_flag == 1'b1, "R10 set beats clear", {15'h0, cap_flag}, 16'h1);

      // R13: timestamp holds while idle
      held = cap_value;
      repeat (20) @(negedge clk);
      check(cap_value == held, "R13 hold", cap_value, held);
      check(exp_q.size() == 0, "R6 all predictions seen", 16'(exp_q.size()), 16'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule